// File: doc/BRIEF.md
# Test Access Port with Switchable Serial Input

This block is a boundary-scan style test access port controller for a device with two serial data inputs: the usual `tdi` and a second input, `tdi_alt`. A multiplexer picks which of the two feeds the instruction and data shift paths. The block contains:

- the sixteen-state TAP sequencer,
- an 8-bit instruction register,
- a 32-bit identification register,
- a one-bit bypass register.

The device is meant to sit at the far end of a scan chain, so its `tdo` drives the header directly.

The input can be chosen in two ways:

- **Select pin.** The level on `std_sel` chooses the input. The pin is pulled high on the board, and a high level selects `tdi`.
- **Command.** Four identification instructions in a row, issued while `std_sel` is high, force `tdi_alt` to be the active input. It stays active until the sequencer passes through Test-Logic-Reset.

The command route works by driving only `tms` and `tck`. The Capture-IR pattern equals the identification opcode. A pass of Capture-IR, Exit1-IR, Update-IR therefore issues that instruction without shifting any data.

Top module: `jtag_altin_tap`

## Requirements
- R1: While `trst_n` is low at a rising `tck` edge, the sequencer goes to Test-Logic-Reset. At the following falling edge `tdo_oe` goes low. With `std_sel` high, `alt_active` is low.
- R2: The sequencer follows the standard sixteen-state graph on rising `tck` edges. Five rising edges with `tms` high reach Test-Logic-Reset from any state.
- R3: Test-Logic-Reset loads the identification opcode 8'h01 into the instruction register. Capture-IR loads 8'b0000_0001, which appears on `tdo` least significant bit first during Shift-IR.
- R4: With the identification opcode active, Capture-DR loads the 32-bit `ID_VALUE` parameter. Shift-DR sends it out on `tdo` least significant bit first.
- R5: Opcode 8'hFF, and any opcode other than 8'h01, selects the one-bit bypass register. It captures 0 and delays the serial input by one `tck` period.
- R6: `tdo` and `tdo_oe` change on falling `tck` edges. `tdo_oe` is high only while the sequencer is in Shift-IR or Shift-DR.
- R7: With `std_sel` high and no command override, the shift paths take `tdi`, and `tdi_alt` has no effect on `tdo`.
- R8: With `std_sel` low, the shift paths take `tdi_alt` and `tdi` has no effect. `alt_active` is high from the first rising edge that samples `std_sel` low.
- R9: An Update-IR with opcode 8'h01 latched counts toward a run that saturates at four. When such an Update-IR makes the run four or more while `std_sel` is high, `alt_active` goes high at the second rising edge after it. This is possible with `tms` alone.
- R10: An Update-IR with any other opcode, or a pass through Test-Logic-Reset, clears the run. An interrupted run never sets the override.
- R11: Once set, the override keeps `tdi_alt` active whatever `tdi` and `std_sel` do. It is cleared in Test-Logic-Reset, and `alt_active` then falls within two rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising `tck` |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Standard serial data input |
| tdi_alt | input | 1 | Alternate serial data input |
| std_sel | input | 1 | Input select pin: 1 = `tdi`, 0 = `tdi_alt` (pulled high externally) |
| tdo | output | 1 | Serial data output, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| alt_active | output | 1 | High while `tdi_alt` feeds the shift paths |

## Verification
Each shifted bit appears on `tdo` at the falling edge that follows the rising edge on which the sequencer entered, or stayed in, the shift state. The bench therefore samples `tdo` and `tdo_oe` one nanosecond after every falling edge, before it drives the next `tms` and data values. Bypass output trails the input by exactly one sample. `alt_active` is due one rising edge after `std_sel` changes. After the override it is due two rising edges after the deciding Update-IR, and likewise after a pass through Test-Logic-Reset. Each status check is taken only after the bench has stepped past those edges with `tms` held low in Run-Test/Idle.

// File: rtl/jtag_alt_pkg.sv
// Shared types for the switchable-input test access port.
// Assumes: the state encoding is private to this block; nothing outside decodes it.
package jtag_alt_pkg;
    typedef enum logic [3:0] {
        ST_RESET  = 4'hF,
        ST_IDLE   = 4'hC,
        ST_SEL_DR = 4'h7,
        ST_CAP_DR = 4'h6,
        ST_SH_DR  = 4'h2,
        ST_X1_DR  = 4'h1,
        ST_PS_DR  = 4'h3,
        ST_X2_DR  = 4'h0,
        ST_UP_DR  = 4'h5,
        ST_SEL_IR = 4'h4,
        ST_CAP_IR = 4'hE,
        ST_SH_IR  = 4'hA,
        ST_X1_IR  = 4'h9,
        ST_PS_IR  = 4'hB,
        ST_X2_IR  = 4'h8,
        ST_UP_IR  = 4'hD
    } tap_state_e;
endpackage

// File: rtl/tap_seq.sv
// Sixteen-state sequencer of the test access port.
// Advances on each rising tck edge from the sampled tms level.
// Assumes: rst_n is the synchronous, active-low test reset.
module tap_seq
    import jtag_alt_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e nxt;

    // Next-state decode of the standard TAP graph.
    always_comb begin
        unique case (state)
            ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_X1_DR  : ST_SH_DR;
            ST_SH_DR:  nxt = tms ? ST_X1_DR  : ST_SH_DR;
            ST_X1_DR:  nxt = tms ? ST_UP_DR  : ST_PS_DR;
            ST_PS_DR:  nxt = tms ? ST_X2_DR  : ST_PS_DR;
            ST_X2_DR:  nxt = tms ? ST_UP_DR  : ST_SH_DR;
            ST_UP_DR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_X1_IR  : ST_SH_IR;
            ST_SH_IR:  nxt = tms ? ST_X1_IR  : ST_SH_IR;
            ST_X1_IR:  nxt = tms ? ST_UP_IR  : ST_PS_IR;
            ST_PS_IR:  nxt = tms ? ST_X2_IR  : ST_PS_IR;
            ST_X2_IR:  nxt = tms ? ST_UP_IR  : ST_SH_IR;
            ST_UP_IR:  nxt = tms ? ST_SEL_DR : ST_IDLE;
            default:   nxt = ST_RESET;
        endcase
    end

    // State register with synchronous test reset.
    always_ff @(posedge tck) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= nxt;
    end

    // R2: holding tms high keeps the sequencer in Test-Logic-Reset.
    a_r2_reset_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET && tms) |=> (state == ST_RESET));

    // R2: a low tms in Run-Test/Idle stays in Run-Test/Idle.
    a_r2_idle_hold: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_IDLE && !tms) |=> (state == ST_IDLE));
endmodule

// File: rtl/tap_regs.sv
// Instruction, identification and bypass registers, plus the tdo driver.
// Shift paths sample din on rising tck. tdo and tdo_oe update on falling tck.
// Assumes: din is already the selected serial input, stable across each bit.
module tap_regs
    import jtag_alt_pkg::*;
#(
    parameter int          IR_W     = 8,
    parameter int          ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1C3A_5E07
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            din,
    output logic [IR_W-1:0] ir_shift,
    output logic            tdo,
    output logic            tdo_oe
);
    localparam logic [IR_W-1:0] OP_ID    = IR_W'(1);
    localparam logic [IR_W-1:0] CAP_PAT  = IR_W'(1);

    logic [IR_W-1:0] ir_q;
    logic [ID_W-1:0] id_shift;
    logic            byp;
    logic            sel_id;

    assign sel_id = (ir_q == OP_ID);

    // Instruction shift stage: capture the fixed pattern, then shift from din.
    always_ff @(posedge tck) begin
        if (!rst_n)                 ir_shift <= CAP_PAT;
        else if (state == ST_CAP_IR) ir_shift <= CAP_PAT;
        else if (state == ST_SH_IR)  ir_shift <= {din, ir_shift[IR_W-1:1]};
    end

    // Active instruction: preset to the identification opcode, loaded at Update-IR.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) ir_q <= OP_ID;
        else if (state == ST_UP_IR)      ir_q <= ir_shift;
    end

    // Identification register: capture the constant, shift toward tdo.
    always_ff @(posedge tck) begin
        if (!rst_n)                              id_shift <= ID_VALUE;
        else if (state == ST_CAP_DR && sel_id)   id_shift <= ID_VALUE;
        else if (state == ST_SH_DR && sel_id)    id_shift <= {din, id_shift[ID_W-1:1]};
    end

    // Bypass bit: capture zero, pass din through with one period of delay.
    always_ff @(posedge tck) begin
        if (!rst_n)                             byp <= 1'b0;
        else if (state == ST_CAP_DR)            byp <= 1'b0;
        else if (state == ST_SH_DR && !sel_id)  byp <= din;
    end

    // Output driver on the falling edge: pick the shifting register's low bit.
    always_ff @(negedge tck) begin
        if (!rst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
            if (state == ST_SH_IR)      tdo <= ir_shift[0];
            else if (state == ST_SH_DR) tdo <= sel_id ? id_shift[0] : byp;
        end
    end

    // R3: Test-Logic-Reset leaves the identification opcode active.
    a_r3_reset_loads_id: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_RESET) |=> (ir_q == OP_ID));

    // R4: Capture-DR under the identification opcode loads the constant.
    a_r4_id_capture: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_CAP_DR && sel_id) |=> (id_shift == ID_VALUE));

    // R5: the bypass bit holds the previous serial input bit.
    a_r5_bypass_delay: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_SH_DR && !sel_id) |=> (byp == $past(din)));

    // R6: the output is enabled only in a shift state.
    a_r6_oe_in_shift: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));
endmodule

// File: rtl/alt_select.sv
// Chooses the active serial input. The select pin low forces the alternate input.
// A run of RUN_LEN identification issues with the pin high sets a sticky override.
// Test-Logic-Reset clears both the run and the override.
// Assumes: ir_shift is the value that is latched into the instruction register at Update-IR.
module alt_select
    import jtag_alt_pkg::*;
#(
    parameter int IR_W    = 8,
    parameter int RUN_LEN = 4
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic [IR_W-1:0] ir_shift,
    input  logic            std_sel,
    output logic            alt_active
);
    localparam int              CW    = $clog2(RUN_LEN + 1);
    localparam logic [IR_W-1:0] OP_ID = IR_W'(1);
    localparam logic [CW-1:0]   RUN_TOP  = CW'(RUN_LEN);
    localparam logic [CW-1:0]   RUN_LAST = CW'(RUN_LEN - 1);

    logic [CW-1:0] run;
    logic          cmd;

    // Run counter and sticky override, both cleared in Test-Logic-Reset.
    always_ff @(posedge tck) begin
        if (!rst_n || state == ST_RESET) begin
            run <= '0;
            cmd <= 1'b0;
        end else if (state == ST_UP_IR) begin
            if (ir_shift == OP_ID) begin
                if (run != RUN_TOP) run <= run + 1'b1;
                if (run >= RUN_LAST && std_sel) cmd <= 1'b1;
            end else begin
                run <= '0;
            end
        end
    end

    // Registered input choice, so the multiplexer only moves on a tck edge.
    always_ff @(posedge tck) begin
        if (!rst_n) alt_active <= 1'b0;
        else        alt_active <= !std_sel || cmd;
    end

    // R9: a completing run with the pin high sets the override.
    a_r9_run_sets_override: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_UP_IR && ir_shift == OP_ID && run >= RUN_LAST && std_sel) |=> cmd);

    // R10: any other opcode at Update-IR clears the run.
    a_r10_other_clears: assert property (@(posedge tck) disable iff (!rst_n)
        (state == ST_UP_IR && ir_shift != OP_ID) |=> (run == '0));

    // R10: the run never passes its saturation value.
    a_r10_saturates: assert property (@(posedge tck) disable iff (!rst_n)
        run <= RUN_TOP);

    // R11: the override holds until Test-Logic-Reset.
    a_r11_override_holds: assert property (@(posedge tck) disable iff (!rst_n)
        (cmd && state != ST_RESET) |=> cmd);

    // R8: a low select pin makes the alternate input active at the next edge.
    a_r8_pin_low: assert property (@(posedge tck) disable iff (!rst_n)
        !std_sel |=> alt_active);
endmodule

// File: rtl/jtag_altin_tap.sv
// Top level: a test access port whose serial input comes from tdi or tdi_alt.
// Assumes: trst_n is sampled on rising tck, std_sel is pulled high on the board,
// and this device is the last one in the chain.
module jtag_altin_tap
    import jtag_alt_pkg::*;
#(
    parameter int              IR_W     = 8,
    parameter int              ID_W     = 32,
    parameter int              RUN_LEN  = 4,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h1C3A_5E07
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    input  logic tdi_alt,
    input  logic std_sel,
    output logic tdo,
    output logic tdo_oe,
    output logic alt_active
);
    tap_state_e      state;
    logic [IR_W-1:0] ir_shift;
    logic            din;

    // Serial input multiplexer, steered by the registered status flag.
    assign din = alt_active ? tdi_alt : tdi;

    tap_seq u_seq (
        .tck   (tck),
        .rst_n (trst_n),
        .tms   (tms),
        .state (state)
    );

    tap_regs #(
        .IR_W     (IR_W),
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_regs (
        .tck      (tck),
        .rst_n    (trst_n),
        .state    (state),
        .din      (din),
        .ir_shift (ir_shift),
        .tdo      (tdo),
        .tdo_oe   (tdo_oe)
    );

    alt_select #(
        .IR_W    (IR_W),
        .RUN_LEN (RUN_LEN)
    ) u_sel (
        .tck        (tck),
        .rst_n      (trst_n),
        .state      (state),
        .ir_shift   (ir_shift),
        .std_sel    (std_sel),
        .alt_active (alt_active)
    );
endmodule

// File: tb/tb_jtag_altin_tap.sv
module tb_jtag_altin_tap;
    localparam logic [31:0] ID_VAL = 32'h1C3A_5E07;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdi_alt = 1'b0;
    logic std_sel = 1'b1;
    logic tdo, tdo_oe, alt_active;
    logic s_tdo, s_oe, s_alt;
    int   checks = 0;
    int   errors = 0;

    always #10 tck = ~tck;

    jtag_altin_tap #(.ID_VALUE(ID_VAL)) dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdi_alt(tdi_alt),
        .std_sel(std_sel), .tdo(tdo), .tdo_oe(tdo_oe), .alt_active(alt_active)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Sample outputs just after a falling edge, then drive for the next rising edge.
    task automatic step(input logic m, input logic d, input logic a);
        @(negedge tck); #1;
        s_tdo = tdo; s_oe = tdo_oe; s_alt = alt_active;
        tms = m; tdi = d; tdi_alt = a;
        @(posedge tck);
    endtask

    task automatic rstep(input logic m);
        step(m, 1'($urandom), 1'($urandom));
    endtask

    task automatic peek();
        @(negedge tck); #1;
        s_tdo = tdo; s_oe = tdo_oe; s_alt = alt_active;
    endtask

    task automatic set_sel(input logic v);
        @(negedge tck); #1;
        std_sel = v;
    endtask

    task automatic goto_tlr();
        repeat (5) rstep(1'b1);
        rstep(1'b0);
    endtask

    // One identification issue using tms only: Capture-IR, Exit1-IR, Update-IR.
    task automatic blind_issue();
        rstep(1'b1); rstep(1'b1); rstep(1'b0); rstep(1'b1); rstep(1'b1); rstep(1'b0);
    endtask

    task automatic load_ir(input logic [7:0] op, input logic via_alt, output logic [7:0] cap);
        rstep(1'b1); rstep(1'b1); rstep(1'b0); rstep(1'b0);
        for (int i = 0; i < 8; i++) begin
            logic r;
            r = 1'($urandom);
            step(i == 7, via_alt ? r : op[i], via_alt ? op[i] : r);
            cap[i] = s_tdo;
        end
        rstep(1'b1); rstep(1'b0);
    endtask

    task automatic shift_dr(input int n, input logic [31:0] din, input logic via_alt,
                            output logic [31:0] dout, output logic oe_all);
        rstep(1'b1); rstep(1'b0); rstep(1'b0);
        dout = '0;
        oe_all = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic r;
            r = 1'($urandom);
            step(i == n - 1, via_alt ? r : din[i], via_alt ? din[i] : r);
            dout[i] = s_tdo;
            oe_all &= s_oe;
        end
        rstep(1'b1); rstep(1'b0);
    endtask

    function automatic logic [31:0] exp_bypass(input int n, input logic [31:0] din);
        logic [31:0] e;
        e = '0;
        for (int i = 1; i < n; i++) e[i] = din[i-1];
        return e;
    endfunction

    function automatic logic [31:0] exp_id(input int n);
        logic [31:0] e;
        e = '0;
        for (int i = 0; i < n; i++) e[i] = ID_VAL[i];
        return e;
    endfunction

    initial begin
        repeat (150000) @(posedge tck);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0]  cap;
        logic [31:0] dout, din;
        logic        oe_all;
        int          seed;
        seed = $urandom(32'd2718);

        // R1: reset state.
        repeat (3) @(posedge tck);
        peek();
        chk("R1 oe in reset", 32'(s_oe), 32'd0);
        chk("R1 alt in reset", 32'(s_alt), 32'd0);
        trst_n = 1'b1;
        rstep(1'b0);

        // R1/R4/R6: identification read right after reset.
        shift_dr(32, $urandom, 1'b0, dout, oe_all);
        chk("R4 idcode lsb first", dout, ID_VAL);
        chk("R6 oe during shift", 32'(oe_all), 32'd1);
        peek();
        chk("R6 oe in idle", 32'(s_oe), 32'd0);

        // R3/R5/R7: capture pattern and bypass through tdi.
        load_ir(8'hFF, 1'b0, cap);
        chk("R3 capture pattern", 32'(cap), 32'h01);
        din = 32'hA5C3_0F69;
        shift_dr(20, din, 1'b0, dout, oe_all);
        chk("R5 R7 bypass echo tdi", dout, exp_bypass(20, din));

        // R5: undefined opcode acts as bypass.
        load_ir(8'h5A, 1'b0, cap);
        din = 32'h0000_3B6D;
        shift_dr(14, din, 1'b0, dout, oe_all);
        chk("R5 undefined opcode bypass", dout, exp_bypass(14, din));

        // R7/R8: random modes, opcodes and lengths.
        for (int it = 0; it < 24; it++) begin
            logic v;
            logic [7:0] op;
            int n, k;
            v = (it % 3 == 0) ? 1'b0 : 1'($urandom);
            set_sel(v);
            rstep(1'b0);
            peek();
            chk(v ? "R7 alt low with pin high" : "R8 alt high with pin low", 32'(s_alt), 32'(!v));
            k = $urandom % 3;
            op = (k == 0) ? 8'h01 : (k == 1) ? 8'hFF : 8'($urandom);
            if (k == 2 && op == 8'h01) op = 8'h02;
            load_ir(op, !v, cap);
            n = 1 + ($urandom % 32);
            din = $urandom;
            shift_dr(n, din, !v, dout, oe_all);
            chk(v ? "R7 data path from tdi" : "R8 data path from tdi_alt", dout,
                (op == 8'h01) ? exp_id(n) : exp_bypass(n, din));
            set_sel(1'b1);
            goto_tlr();
        end

        // R9/R10: an interrupted run does not set the override.
        repeat (3) blind_issue();
        rstep(1'b0); peek();
        chk("R9 three issues not enough", 32'(s_alt), 32'd0);
        load_ir(8'hFF, 1'b0, cap);
        repeat (3) blind_issue();
        rstep(1'b0); peek();
        chk("R10 run cleared by other opcode", 32'(s_alt), 32'd0);
        blind_issue();
        rstep(1'b0); peek();
        chk("R9 fourth issue sets override", 32'(s_alt), 32'd1);

        // R11: tdi ignored, pin toggles ignored while the override holds.
        load_ir(8'hFF, 1'b1, cap);
        din = 32'h6E1D_94B2;
        shift_dr(32, din, 1'b1, dout, oe_all);
        chk("R11 tdi ignored under override", dout, exp_bypass(32, din));
        set_sel(1'b0); rstep(1'b0);
        set_sel(1'b1); rstep(1'b0); rstep(1'b0); peek();
        chk("R11 override survives pin toggle", 32'(s_alt), 32'd1);

        // R11: Test-Logic-Reset returns the choice to tdi.
        goto_tlr(); rstep(1'b0); peek();
        chk("R11 cleared by reset state", 32'(s_alt), 32'd0);
        load_ir(8'hFF, 1'b0, cap);
        din = 32'h0000_0D2B;
        shift_dr(12, din, 1'b0, dout, oe_all);
        chk("R7 tdi active after reset state", dout, exp_bypass(12, din));

        // R9: run gathered with the pin low, completed by a later issue with the pin high.
        goto_tlr();
        set_sel(1'b0);
        repeat (4) blind_issue();
        set_sel(1'b1); rstep(1'b0); rstep(1'b0); peek();
        chk("R9 no override while pin low", 32'(s_alt), 32'd0);
        blind_issue();
        rstep(1'b0); peek();
        chk("R9 saturated run sets override", 32'(s_alt), 32'd1);

        // R2: five tms-high edges from Shift-DR reach Test-Logic-Reset.
        goto_tlr(); rstep(1'b0);
        load_ir(8'hFF, 1'b0, cap);
        rstep(1'b1); rstep(1'b0); rstep(1'b0);
        goto_tlr();
        shift_dr(32, $urandom, 1'b0, dout, oe_all);
        chk("R2 reset state reached from Shift-DR", dout, ID_VAL);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule